// File: doc/BRIEF.md
# Block-Buffer DMA Controller

This controller carries one block of device data into main memory. Software uses a small register-write port to program three values: a block address that is presented to the device, a destination memory address and a byte count. It then writes a start bit. The controller asserts a request toward the device and takes in the data bytes, followed by one trailing checksum byte. It keeps the data bytes in an internal staging buffer.

The controller issues no memory write until the whole block is held and its checksum matches. It then sends the staged bytes one at a time over a valid/ready memory write port. The address goes up and the remaining count goes down only when a write is accepted. When the count reaches zero, the controller raises an interrupt. If the checksum does not match, the memory is not touched: the controller stops in an error state and raises the same interrupt. The interrupt stays high until software clears it.

Register selects are 0 for the device block address, 1 for the memory address, 2 for the count (bits 8:0) and 3 for control. In the control register, bit 0 starts a transfer and bit 1 clears the interrupt. The status codes are 0 idle, 1 filling, 2 checking, 3 copying, 4 done and 5 error.

Top module: `blk_dma`

## Requirements
- R1: After reset, status is 0 (idle), and irq, mem_valid and dev_req are low.
- R2: A start (select 3, bit 0) issued in idle with a count from 1 to 256 moves status to 1 (filling) on the next cycle. It also raises dev_req and drives dev_blk_addr with the programmed block address.
- R3: mem_valid stays low while filling and while checking. No memory write happens before all count data bytes and the trailing checksum byte have been accepted.
- R4: If the modulo-256 sum of the data bytes differs from the trailing byte, status becomes 5 (error) and irq rises, with no memory write at all.
- R5: The n-th accepted write (mem_valid and mem_ready both high) carries data byte n to address start+n, wrapping modulo 2^AW. While mem_ready is low, address and data hold steady.
- R6: A block with a good checksum produces exactly count writes, after which status is 4 (done) and irq is high.
- R7: A start with a count of 0 goes straight to done with irq high on the next cycle. No device request and no memory write take place.
- R8: A start with a count above 256 goes straight to error with irq high.
- R9: irq stays high until a control write with bit 1 set. That write returns status to idle and drops irq.
- R10: Register writes and start requests that arrive outside idle have no effect on the transfer in progress or on the done state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | AW | Register write data |
| dev_req | output | 1 | Requests block data from the device |
| dev_blk_addr | output | AW | Block address presented to the device |
| dev_valid | input | 1 | Device byte present |
| dev_data | input | 8 | Device byte |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | AW | Memory write address |
| mem_data | output | 8 | Memory write data |
| irq | output | 1 | Completion or error interrupt |
| status | output | 3 | Controller state code |

## Verification
Every register write and every device byte takes effect at the rising edge that samples it, and the new status shows in the cycle after that edge. The checksum decision takes one extra cycle in the checking state, so the first mem_valid appears two cycles after the trailing byte. The bench drives inputs just after a falling edge and samples outputs at the following falling edge, so each observation falls in the cycle where the result is due. Memory writes are compared only in cycles where mem_ready was driven high. Stalled cycles are left to the hold assertion.

// File: rtl/blk_dma.sv
module blk_dma #(
  parameter int AW    = 16,
  parameter int DEPTH = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          dev_req,
  output logic [AW-1:0] dev_blk_addr,
  input  logic          dev_valid,
  input  logic [7:0]    dev_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_data,
  output logic          irq,
  output logic [2:0]    status
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [2:0] S_IDLE = 3'd0, S_FILL = 3'd1, S_CHECK = 3'd2,
                         S_COPY = 3'd3, S_DONE = 3'd4, S_ERR = 3'd5;

  logic [2:0]       state;
  logic [AW-1:0]    blk_q, addr_q;
  logic [CNT_W-1:0] cnt_q, idx_q;
  logic [7:0]       sum_q, chk_q;
  logic [7:0]       stage [DEPTH];

  wire ctrl_wr  = cfg_we && (cfg_sel == 2'd3);
  wire take_dat = (state == S_FILL) && dev_valid && (idx_q != cnt_q);
  wire take_chk = (state == S_FILL) && dev_valid && (idx_q == cnt_q);
  wire accept   = (state == S_COPY) && mem_ready;

  assign dev_req      = (state == S_FILL);
  assign dev_blk_addr = blk_q;
  assign mem_valid    = (state == S_COPY);
  assign mem_addr     = addr_q;
  assign mem_data     = stage[idx_q[IDX_W-1:0]];
  assign irq          = (state == S_DONE) || (state == S_ERR);
  assign status       = state;

  always_ff @(posedge clk)
    if (take_dat) stage[idx_q[IDX_W-1:0]] <= dev_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      blk_q  <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      sum_q  <= '0;
      chk_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (cfg_we) begin
          case (cfg_sel)
            2'd0: blk_q  <= cfg_wdata;
            2'd1: addr_q <= cfg_wdata;
            2'd2: cnt_q  <= cfg_wdata[CNT_W-1:0];
            default: if (cfg_wdata[0]) begin
              idx_q <= '0;
              sum_q <= '0;
              if (cnt_q == '0)        state <= S_DONE;
              else if (cnt_q > DEPTH) state <= S_ERR;
              else                    state <= S_FILL;
            end
          endcase
        end
        S_FILL: begin
          if (take_dat) begin
            sum_q <= sum_q + dev_data;
            idx_q <= idx_q + 1'b1;
          end
          if (take_chk) begin
            chk_q <= dev_data;
            idx_q <= '0;
            state <= S_CHECK;
          end
        end
        S_CHECK: state <= (sum_q == chk_q) ? S_COPY : S_ERR;
        S_COPY: if (accept) begin
          addr_q <= addr_q + 1'b1;
          cnt_q  <= cnt_q - 1'b1;
          idx_q  <= idx_q + 1'b1;
          if (cnt_q == 1) state <= S_DONE;
        end
        S_DONE, S_ERR: if (ctrl_wr && cfg_wdata[1]) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blk_dma_chk.sv
module blk_dma_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel,
  input logic [AW-1:0] cfg_wdata,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_data,
  input logic          irq,
  input logic [2:0]    status
);
  // R3
  no_early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd1 || status == 3'd2) |-> !mem_valid);

  // R4
  err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd5) |-> (!mem_valid && irq));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (!mem_valid || mem_addr == AW'($past(mem_addr) + 1'b1)));

  // R6
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd4) |-> (irq && !mem_valid));

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(cfg_we && cfg_sel == 2'd3 && cfg_wdata[1])) |=> irq);
endmodule

bind blk_dma blk_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq), .status(status)
);

// File: tb/sim_blk_dma.sv
module sim_blk_dma;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  // {mem addr 16, count 9, seed 8, bad checksum, stall, busy poke}
  localparam int NV = 6;
  localparam logic [35:0] VEC [NV] = '{
    {16'h1000, 9'd1,   8'h05, 1'b0, 1'b0, 1'b0},
    {16'h2000, 9'd16,  8'h11, 1'b0, 1'b1, 1'b0},
    {16'hFFFE, 9'd5,   8'h80, 1'b0, 1'b0, 1'b0},
    {16'h0300, 9'd256, 8'h3C, 1'b0, 1'b1, 1'b0},
    {16'h0400, 9'd8,   8'h22, 1'b1, 1'b0, 1'b0},
    {16'h0500, 9'd4,   8'h09, 1'b0, 1'b0, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [AW-1:0] cfg_wdata = 0;
  logic dev_req, dev_valid = 0;
  logic [7:0] dev_data = 0;
  logic mem_valid, mem_ready = 0;
  logic [AW-1:0] mem_addr, dev_blk_addr;
  logic [7:0] mem_data;
  logic irq;
  logic [2:0] status;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_dma #(.AW(AW)) u0 (.*);

  function automatic logic [7:0] pat(input logic [7:0] s, input int i);
    return s + 8'(i * 7);
  endfunction

  task automatic check_eq(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int data);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = AW'(data);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic xfer(input logic [35:0] v);
    logic [15:0] maddr = v[35:20];
    int cnt = int'(v[19:11]);
    logic [7:0] seed = v[10:3];
    bit bad = v[2], stall = v[1], poke = v[0];
    logic [7:0] csum = 0;
    int i = 0, k = 0, n = 0;
    bit early = 0;
    for (int j = 0; j < cnt; j++) csum += pat(seed, j);
    csum += 8'(bad);
    wr(1, maddr); wr(0, 16'hB000 + cnt); wr(2, cnt); wr(3, 1);
    check_eq("R2 status", status, 1);
    check_eq("R2 dev_req", dev_req, 1);
    check_eq("R2 blk addr", dev_blk_addr, 16'hB000 + cnt);
    if (poke) begin
      wr(2, cnt + 3); wr(1, 16'h7777); wr(3, 1);
      check_eq("R10 still filling", status, 1);
    end
    while (i <= cnt) begin
      bit gap = stall && (k % 2 == 1);
      k++;
      dev_valid = !gap;
      dev_data = (i < cnt) ? pat(seed, i) : csum;
      if (mem_valid) early = 1;
      @(negedge clk);
      if (!gap) i++;
    end
    dev_valid = 0;
    check_eq("R3 no early write", early, 0);
    check_eq("R3 checking", status, 2);
    check_eq("R3 valid low in check", mem_valid, 0);
    for (int cyc = 0; cyc < 2000; cyc++) begin
      bit rdy = stall ? (cyc % 3 != 2) : 1'b1;
      mem_ready = rdy;
      #1;
      if (status != 3'd2 && status != 3'd3) break;
      if (mem_valid && rdy) begin
        check_eq("R5 addr", mem_addr, 16'(maddr + 16'(n)));
        check_eq("R5 data", mem_data, pat(seed, n));
        n++;
      end
      @(negedge clk);
    end
    mem_ready = 0;
    if (bad) begin
      check_eq("R4 writes", n, 0);
      check_eq("R4 status", status, 5);
      check_eq("R4 irq", irq, 1);
    end else begin
      check_eq("R6 writes", n, cnt);
      check_eq("R6 status", status, 4);
      check_eq("R6 irq", irq, 1);
      if (poke) check_eq("R10 count kept", n, cnt);
    end
    @(negedge clk);
    repeat (4) @(negedge clk);
    check_eq("R9 irq held", irq, 1);
    wr(3, 2);
    check_eq("R9 idle", status, 0);
    check_eq("R9 irq low", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_eq("R1 status", status, 0);
    check_eq("R1 irq", irq, 0);
    check_eq("R1 mem_valid", mem_valid, 0);
    check_eq("R1 dev_req", dev_req, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) xfer(VEC[v]);

    wr(2, 0); wr(3, 1);
    check_eq("R7 status", status, 4);
    check_eq("R7 irq", irq, 1);
    check_eq("R7 dev_req", dev_req, 0);
    check_eq("R7 mem_valid", mem_valid, 0);
    wr(3, 1);
    check_eq("R10 start in done", status, 4);
    wr(3, 2);
    check_eq("R9 clear", status, 0);

    wr(2, 300); wr(3, 1);
    check_eq("R8 status", status, 5);
    check_eq("R8 irq", irq, 1);
    check_eq("R8 dev_req", dev_req, 0);
    wr(3, 2);
    check_eq("R9 clear err", irq, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule